// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral on a simple word-addressed register bus. A 15-bit down-counter counts in units of one slow tick, nominally 10 ms, given by a one-cycle tick-enable input. Every control action must carry a 16-bit key value. A write with the wrong value, or one that breaks a required order, changes nothing. The counter is reloaded by a feed key. It is stopped by a two-write key sequence and started again by a resume key.

One tick before the count runs out, the block sets a pre-timeout event. The event can be routed to an interrupt line through a mask bit. On the next tick the block emits a single-cycle reset pulse, records the timeout in a status register that reads back as a coded word, and reloads the counter from the last programmed timeout. Software can read the live count, with a flag that marks a value that has just changed. A debug-mode input freezes counting unless software has set an override bit.

Top module: `keyed_watchdog`

## Requirements
- R1: A write of 0xFEED to offset 0x00 reloads the count from the timeout register in the next cycle. Any other value written there leaves the count unchanged.
- R2: A write to offset 0x04 stores data bits [14:0] as the timeout, and offset 0x04 reads it back with bit 15 at zero. While the timer is enabled and not frozen, each tick lowers the count by one.
- R3: A write of 0x2BAD to offset 0x08, followed by a write of 0xCAFE to offset 0x0C as the very next write, disables the timer. Offset 0x0C then reads 0xDABE, and ticks leave the count unchanged. Any other write between the two steps aborts the sequence, and 0xCAFE without a preceding first step is ignored.
- R4: A write of 0xACED to offset 0x1C re-enables the timer. Offset 0x0C then reads 0x0000, and counting resumes from the held count.
- R5: A tick that brings the count from 2 to 1 sets the event bit, bit 0 of offset 0x20. The interrupt output equals the event AND the mask bit, bit 0 of offset 0x24. Writing 1 to bit 0 of offset 0x20 clears the event.
- R6: A tick taken while the count is 1 or 0 produces a reset pulse exactly one cycle wide and reloads the count from the timeout register.
- R7: Offset 0x10 reads 0xCFE8 after an expiry and 0x0000 otherwise. Writing 0xE8B4 returns it to 0x0000, and any other value written there is ignored.
- R8: Offset 0x14 reads the count in bits [14:0]. Bit 15 reads 1 only in the one cycle that follows a tick-driven change of the count.
- R9: Offset 0x18 reads the debug-mode input in bit 1 and a stored override in bit 0, which is written through bit 0. With debug mode high and the override clear, ticks leave the count unchanged. With the override set, counting continues.
- R10: Writing 1 to bit 0 of offset 0x28 sets the event bit. The register itself reads 0.
- R11: After reset the timer is enabled with count and timeout equal to DEF_TIMEOUT, and status, event, mask and override are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per count unit |
| dbg_mode | input | 1 | Debug halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; word aligned |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Pre-timeout interrupt |
| wdt_reset | output | 1 | One-cycle reset pulse at expiry |

## Verification
The assertions assume that tick_en, dbg_mode and the bus strobes are synchronous to clk, and that the bus sends at most one write per cycle. They also assume that no feed lands on the cycle of a tick they judge, because a feed legitimately overrides the tick. The bench drives every input at the falling edge, keeps ticks and writes in separate cycles, and only changes dbg_mode between ticks. Under these conditions each assertion's premise matches a case that the requirements fully define.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_DW = 16;
  localparam int WDT_CW = 15;

  localparam logic [3:0] IDX_FEED  = 4'h0;
  localparam logic [3:0] IDX_TMO   = 4'h1;
  localparam logic [3:0] IDX_DIS1  = 4'h2;
  localparam logic [3:0] IDX_DIS2  = 4'h3;
  localparam logic [3:0] IDX_STAT  = 4'h4;
  localparam logic [3:0] IDX_CNT   = 4'h5;
  localparam logic [3:0] IDX_DBG   = 4'h6;
  localparam logic [3:0] IDX_RSM   = 4'h7;
  localparam logic [3:0] IDX_EVT   = 4'h8;
  localparam logic [3:0] IDX_MASK  = 4'h9;
  localparam logic [3:0] IDX_FRC   = 4'hA;

  localparam logic [WDT_DW-1:0] KEY_FEED   = 16'hFEED;
  localparam logic [WDT_DW-1:0] KEY_DIS1   = 16'h2BAD;
  localparam logic [WDT_DW-1:0] KEY_DIS2   = 16'hCAFE;
  localparam logic [WDT_DW-1:0] KEY_RESUME = 16'hACED;
  localparam logic [WDT_DW-1:0] KEY_SCLR   = 16'hE8B4;
  localparam logic [WDT_DW-1:0] CODE_OFF   = 16'hDABE;
  localparam logic [WDT_DW-1:0] CODE_TOUT  = 16'hCFE8;

  typedef struct packed {
    logic any_wr;
    logic feed;
    logic tmo_wr;
    logic dis1;
    logic dis2;
    logic resume;
    logic stat_clr;
    logic dbg_wr;
    logic evt_ack;
    logic mask_wr;
    logic force_evt;
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_cmd_decode.sv
module wdt_cmd_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WDT_DW-1:0] wdata,
  output wdt_cmd_t          cmd
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = addr[ADDR_W-1:2];
  assign hit = wr_en && (addr[1:0] == 2'b00);

  function automatic logic sel(input logic [IDX_W-1:0] i, input logic [3:0] r);
    return i == IDX_W'(r);
  endfunction

  always_comb begin
    cmd           = '0;
    cmd.any_wr    = hit;
    cmd.feed      = hit && sel(idx, IDX_FEED) && (wdata == KEY_FEED);
    cmd.tmo_wr    = hit && sel(idx, IDX_TMO);
    cmd.dis1      = hit && sel(idx, IDX_DIS1) && (wdata == KEY_DIS1);
    cmd.dis2      = hit && sel(idx, IDX_DIS2) && (wdata == KEY_DIS2);
    cmd.resume    = hit && sel(idx, IDX_RSM) && (wdata == KEY_RESUME);
    cmd.stat_clr  = hit && sel(idx, IDX_STAT) && (wdata == KEY_SCLR);
    cmd.dbg_wr    = hit && sel(idx, IDX_DBG);
    cmd.evt_ack   = hit && sel(idx, IDX_EVT) && wdata[0];
    cmd.mask_wr   = hit && sel(idx, IDX_MASK);
    cmd.force_evt = hit && sel(idx, IDX_FRC) && wdata[0];
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cmd_t cmd,
  output logic     en_q
);
  logic armed_q, armed_d, en_d;

  always_comb begin
    armed_d = armed_q;
    en_d    = en_q;
    if (cmd.any_wr) armed_d = cmd.dis1;
    if (cmd.dis2 && armed_q) en_d = 1'b0;
    else if (cmd.resume)     en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      armed_q <= armed_d;
      en_q    <= en_d;
    end
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int                CNT_W    = 15,
  parameter logic [CNT_W-1:0]  RST_LOAD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fresh_q,
  output logic             warn,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_d;
  logic             fresh_d, step;

  assign step   = run && tick_en && !load;
  assign expire = step && (cnt_q <= ONE);
  assign warn   = step && (cnt_q == TWO);

  always_comb begin
    cnt_d   = cnt_q;
    fresh_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (expire) begin
      cnt_d   = load_val;
      fresh_d = 1'b1;
    end else if (step) begin
      cnt_d   = cnt_q - ONE;
      fresh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_LOAD;
      fresh_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
    end
  end
endmodule

// File: rtl/wdt_event_ctl.sv
module wdt_event_ctl
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cmd_t cmd,
  input  logic     mask_bit,
  input  logic     warn,
  output logic     evt_q,
  output logic     mask_q,
  output logic     irq
);
  logic evt_d, mask_d;

  always_comb begin
    evt_d  = evt_q;
    mask_d = mask_q;
    if (cmd.evt_ack)            evt_d  = 1'b0;
    if (warn || cmd.force_evt)  evt_d  = 1'b1;
    if (cmd.mask_wr)            mask_d = mask_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  assign irq = evt_q && mask_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [WDT_CW-1:0] DEF_TIMEOUT = 15'd6000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WDT_DW-1:0] wdata,
  output logic [WDT_DW-1:0] rdata,
  output logic              irq,
  output logic              wdt_reset
);
  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = sync_q[SYNC_STAGES-1];

  wdt_cmd_t          cmd;
  logic              en_q, run, feed;
  logic [WDT_CW-1:0] tmo_q, tmo_d, cnt_q;
  logic              fresh_q, warn, expire;
  logic              evt_q, mask_q;
  logic              status_q, status_d, keep_q, keep_d, pulse_q;
  logic [WDT_DW-1:0] rdata_q, rdata_d;

  wdt_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en), .addr (addr), .wdata (wdata), .cmd (cmd)
  );

  wdt_key_seq u_seq (
    .clk (clk), .rst_n (rst_s), .cmd (cmd), .en_q (en_q)
  );

  assign feed = cmd.feed;
  assign run  = en_q && (!dbg_mode || keep_q);

  wdt_down_counter #(.CNT_W(WDT_CW), .RST_LOAD(DEF_TIMEOUT)) u_cnt (
    .clk (clk), .rst_n (rst_s), .tick_en (tick_en), .run (run),
    .load (feed), .load_val (tmo_q), .cnt_q (cnt_q), .fresh_q (fresh_q),
    .warn (warn), .expire (expire)
  );

  wdt_event_ctl u_evt (
    .clk (clk), .rst_n (rst_s), .cmd (cmd), .mask_bit (wdata[0]),
    .warn (warn), .evt_q (evt_q), .mask_q (mask_q), .irq (irq)
  );

  always_comb begin
    tmo_d    = tmo_q;
    status_d = status_q;
    keep_d   = keep_q;
    if (cmd.tmo_wr)   tmo_d    = wdata[WDT_CW-1:0];
    if (cmd.stat_clr) status_d = 1'b0;
    if (expire)       status_d = 1'b1;
    if (cmd.dbg_wr)   keep_d   = wdata[0];
  end

  always_comb begin
    rdata_d = '0;
    if (addr[1:0] == 2'b00) begin
      case (addr[ADDR_W-1:2])
        IDX_W'(IDX_TMO):  rdata_d = {1'b0, tmo_q};
        IDX_W'(IDX_DIS2): rdata_d = en_q ? '0 : CODE_OFF;
        IDX_W'(IDX_STAT): rdata_d = status_q ? CODE_TOUT : '0;
        IDX_W'(IDX_CNT):  rdata_d = {fresh_q, cnt_q};
        IDX_W'(IDX_DBG):  rdata_d = {14'd0, dbg_mode, keep_q};
        IDX_W'(IDX_EVT):  rdata_d = {15'd0, evt_q};
        IDX_W'(IDX_MASK): rdata_d = {15'd0, mask_q};
        default:          rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tmo_q    <= DEF_TIMEOUT;
      status_q <= 1'b0;
      keep_q   <= 1'b0;
      pulse_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      tmo_q    <= tmo_d;
      status_q <= status_d;
      keep_q   <= keep_d;
      pulse_q  <= expire;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign wdt_reset = pulse_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        dbg_mode,
  input logic        wdt_reset,
  input logic        irq,
  input logic        mask_q,
  input logic        en_q,
  input logic        keep_q,
  input logic        run,
  input logic        feed,
  input logic        status_q,
  input logic [14:0] cnt_q,
  input logic [14:0] tmo_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);                                          // R6
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (cnt_q == $past(tmo_q)));                             // R6
  AST_STATUS_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> status_q);                                            // R7
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !feed) |=> $stable(cnt_q));                               // R3
  AST_FREEZE_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !keep_q && !feed) |=> $stable(cnt_q));                 // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q);                                                    // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && run && !feed && cnt_q > 15'd2) |=>
      (cnt_q == 15'($past(cnt_q) - 15'd1)));                            // R2
endmodule

bind keyed_watchdog wdt_checker u_chk (
  .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .dbg_mode (dbg_mode),
  .wdt_reset (wdt_reset), .irq (irq), .mask_q (mask_q), .en_q (en_q),
  .keep_q (keep_q), .run (run), .feed (feed), .status_q (status_q),
  .cnt_q (cnt_q), .tmo_q (tmo_q)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, dbg_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wdt_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  keyed_watchdog u_dut (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .dbg_mode (dbg_mode),
    .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata),
    .rdata (rdata), .irq (irq), .wdt_reset (wdt_reset)
  );

  // monitor: compares each returned read against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: read %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(6'h0C, 16'h0000, "R11 enabled at reset");
    rd(6'h10, 16'h0000, "R11 status at reset");
    rd(6'h14, 16'd6000, "R11 count at reset");
    rd(6'h04, 16'd6000, "R11 timeout at reset");
    rd(6'h20, 16'h0000, "R11 event at reset");

    // R1 feed key
    wr(6'h04, 16'h8005);
    rd(6'h04, 16'h0005, "R2 timeout readback masked");
    wr(6'h00, 16'h1234);
    rd(6'h14, 16'd6000, "R1 wrong feed ignored");
    wr(6'h00, 16'hFEED);
    rd(6'h14, 16'd5, "R1 feed reloads");

    // R2 / R8 counting and fresh flag
    tick();
    rd(6'h14, 16'h8004, "R8 fresh flag after tick");
    rd(6'h14, 16'h0004, "R8 flag gone, R2 decrement");
    tick(); tick();
    rd(6'h20, 16'h0000, "R5 no event at count 2");
    tick();
    rd(6'h20, 16'h0001, "R5 event at count 1");
    chk(irq, 1'b0, "R5 irq masked");
    wr(6'h24, 16'h0001);
    chk(irq, 1'b1, "R5 irq unmasked");
    wr(6'h20, 16'h0001);
    chk(irq, 1'b0, "R5 irq after ack");

    // R10 force
    wr(6'h28, 16'h0001);
    chk(irq, 1'b1, "R10 force sets event");
    rd(6'h28, 16'h0000, "R10 force reads zero");
    wr(6'h20, 16'h0001);

    // R6 / R7 expiry
    chk(wdt_reset, 1'b0, "R6 no reset before expiry");
    tick();
    chk(wdt_reset, 1'b1, "R6 reset pulse");
    @(negedge clk);
    chk(wdt_reset, 1'b0, "R6 pulse one cycle");
    rd(6'h14, 16'd5, "R6 reload from timeout");
    rd(6'h10, 16'hCFE8, "R7 timed-out code");
    wr(6'h10, 16'h1111);
    rd(6'h10, 16'hCFE8, "R7 wrong clear ignored");
    wr(6'h10, 16'hE8B4);
    rd(6'h10, 16'h0000, "R7 cleared");

    // R3 disable sequence
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'hDABE, "R3 disabled code");
    tick();
    rd(6'h14, 16'd5, "R3 count held while disabled");

    // R4 resume
    wr(6'h1C, 16'hACED);
    rd(6'h0C, 16'h0000, "R4 enabled code");
    tick();
    rd(6'h14, 16'h8004, "R4 counting resumed");

    // R3 aborted and unarmed sequences
    wr(6'h08, 16'h2BAD);
    wr(6'h04, 16'h0005);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'h0000, "R3 intervening write aborts");
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'h0000, "R3 second step alone ignored");

    // R9 debug freeze and override
    dbg_mode = 1'b1;
    rd(6'h18, 16'h0002, "R9 debug indication");
    tick();
    rd(6'h14, 16'd4, "R9 frozen in debug");
    wr(6'h18, 16'h0001);
    tick();
    rd(6'h14, 16'h8003, "R9 override keeps counting");
    rd(6'h18, 16'h0003, "R9 override readback");
    dbg_mode = 1'b0;

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung (actual incomplete, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule